// File: doc/BRIEF.md
# Screen Memory Mirror with Vertical-Sync SPI Burst

This block sits beside a 6502-style processor bus and keeps a private copy of the text screen. Each processor write whose address lands in the 1 KiB screen window (0x0400 to 0x07FF) is caught on its bus strobe. Its offset and data are latched in that same cycle, and the processor is halted through RDY until the byte has been committed to a local mirror RAM at the same offset.

On each rising edge of vertical sync the block pushes the first 1000 mirror bytes (40 columns by 25 rows) to a video controller as a single SPI master burst. The burst runs in mode 0, sends the most significant bit first and keeps chip select low throughout. The mirror RAM is shared between the capture path and the burst reader. A write caught while a burst runs is held, never dropped, and the processor stays halted until the burst ends. A capture that is pending, or that is caught in the very cycle a burst would start, is committed before the burst begins.

Top module: `screen_mirror`

## Requirements
- R1: A strobed bus cycle is captured only when it is a write (cpu_rw = 0) with an address from 0x0400 to 0x07FF inclusive. Reads at any address and writes outside that range leave cpu_rdy high and do not change the mirror.
- R2: The address offset (address minus 0x0400) and the data of a captured write are latched on the strobe's clock edge, and cpu_rdy is low in the following cycle.
- R3: cpu_rdy returns high only after the held byte has been committed to the mirror. When no burst is running, the halt lasts exactly one clock cycle.
- R4: A rising edge of vsync starts a burst that sends mirror offsets 0, 1, 2 and onward in ascending order. Each byte is sent MSB first in SPI mode 0: spi_sclk idles low, and data is valid at each rising spi_sclk edge.
- R5: A burst carries exactly 1000 bytes with spi_cs_n held low for its whole length. It completes within 3 ms of clock time, which is 375000 cycles at 125 MHz; this bound is checked at elaboration from the clock-rate and divider parameters.
- R6: A write captured while a burst runs is not lost. The byte sent in that burst is the old mirror value, cpu_rdy stays low until spi_cs_n has returned high, and the new value appears in the next burst.
- R7: A capture has priority over starting a burst. The burst waits for a pending capture, and for a capture caught in the same cycle, so the halt stays one cycle and the burst carries the new byte.
- R8: A rising edge of vsync that arrives while a burst is running is ignored and does not cause a second burst.
- R9: After reset, cpu_rdy is high, spi_cs_n is high, spi_sclk is low, and no burst runs until the first vsync rising edge.
- R10: spi_sclk stays low whenever spi_cs_n is high, and spi_mosi changes only while spi_sclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_strobe | input | 1 | One-cycle pulse marking a valid bus cycle (PHI2-qualified) |
| vsync | input | 1 | Vertical sync level; a rising edge requests a burst |
| cpu_rdy | output | 1 | Processor ready; low halts the processor |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | SPI data out, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low, low for a whole burst |

## Verification
The assertions take for granted that vsync and the bus signals are synchronous to clk. They also assume cpu_strobe is a single-cycle pulse that is never raised while cpu_rdy is low, because a halted processor issues no new bus cycle. The bench drives every input at the falling clock edge. After each strobe it waits for cpu_rdy to rise before the next access, and it raises vsync a second time during a burst only to exercise the ignored-edge rule. Random addresses are drawn around both window edges so that reads, in-window writes and out-of-window writes are all mixed.

// File: rtl/smir_pkg.sv
package smir_pkg;

   typedef enum logic [1:0] {
      BST_IDLE  = 2'd0,
      BST_FETCH = 2'd1,
      BST_LOAD  = 2'd2,
      BST_SHIFT = 2'd3
   } bst_e;

   // Clock cycles for one full burst: each byte costs one fetch cycle, one
   // load cycle and 2*HALF cycles per bit.
   function automatic longint burst_cycles(input int bytes, input int dw, input int half);
      return longint'(bytes) * (longint'(2) + longint'(2) * longint'(dw) * longint'(half));
   endfunction

   function automatic longint budget_cycles(input longint clk_hz, input longint budget_us);
      return (clk_hz / 64'd1_000_000) * budget_us;
   endfunction

endpackage

// File: rtl/smir_capture.sv
module smir_capture #(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int OW   = 10,
   parameter int BASE = 'h0400
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_data,
   input  logic          cpu_rw,
   input  logic          cpu_strobe,
   input  logic          grant,
   output logic          hit,
   output logic          pending,
   output logic          we,
   output logic [OW-1:0] waddr,
   output logic [DW-1:0] wdata,
   output logic          cpu_rdy
);

   localparam logic [AW-1:0] BASE_V = AW'(BASE);

   logic          in_win;
   logic          pend_q;
   logic [OW-1:0] off_q;
   logic [DW-1:0] dat_q;

   assign in_win = ((cpu_addr >> OW) == (BASE_V >> OW));
   assign hit    = cpu_strobe & ~cpu_rw & in_win & ~pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         off_q  <= '0;
         dat_q  <= '0;
      end else if (hit) begin
         pend_q <= 1'b1;
         off_q  <= cpu_addr[OW-1:0];
         dat_q  <= cpu_data;
      end else if (we) begin
         pend_q <= 1'b0;
      end
   end

   // Commit (internal acknowledge) whenever the mirror port is granted.
   assign we      = pend_q & grant;
   assign waddr   = off_q;
   assign wdata   = dat_q;
   assign pending = pend_q;
   assign cpu_rdy = ~pend_q;

   // R1: a read strobe never starts a capture
   p_read_ignored_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_strobe && cpu_rw && cpu_rdy) |=> cpu_rdy);

   // R2: an in-window write halts the processor in the next cycle
   p_halt_on_hit_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_strobe && !cpu_rw && in_win && cpu_rdy) |=> !cpu_rdy);

   // R3: the halt ends only after a commit
   p_release_after_ack_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rdy) |-> $past(we));

endmodule

// File: rtl/smir_ram.sv
module smir_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/smir_burst.sv
module smir_burst
   import smir_pkg::*;
#(
   parameter int DW    = 8,
   parameter int AW    = 10,
   parameter int BYTES = 1000,
   parameter int HALF  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vsync,
   input  logic          hold,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          spi_sclk,
   output logic          spi_mosi,
   output logic          spi_cs_n
);

   localparam int            BW       = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [AW-1:0] LAST_IDX = AW'(BYTES - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   bst_e          state;
   logic          vsync_d;
   logic          vsync_rise;
   logic          start_req;
   logic [AW-1:0] idx;
   logic [BW-1:0] bit_cnt;
   logic [DW-1:0] shreg;
   logic          sclk_q;
   logic          tick;

   assign vsync_rise = vsync & ~vsync_d;

   // Bit-rate divider: a tick marks the end of each half SPI period.
   generate
      if (HALF == 1) begin : g_div_none
         assign tick = (state == BST_SHIFT);
      end else begin : g_div_cnt
         localparam int            CW  = $clog2(HALF);
         localparam logic [CW-1:0] LIM = CW'(HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                              cnt <= '0;
            else if (state != BST_SHIFT || cnt == LIM) cnt <= '0;
            else                                       cnt <= cnt + 1'b1;
         end
         assign tick = (state == BST_SHIFT) && (cnt == LIM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= BST_IDLE;
         vsync_d   <= 1'b0;
         start_req <= 1'b0;
         idx       <= '0;
         bit_cnt   <= '0;
         shreg     <= '0;
         sclk_q    <= 1'b0;
      end else begin
         vsync_d <= vsync;
         case (state)
            BST_IDLE: begin
               if (start_req && !hold) begin
                  state     <= BST_FETCH;
                  idx       <= '0;
                  start_req <= 1'b0;
               end else if (vsync_rise) begin
                  start_req <= 1'b1;
               end
            end
            BST_FETCH: state <= BST_LOAD;
            BST_LOAD: begin
               shreg   <= rd_data;
               bit_cnt <= '0;
               sclk_q  <= 1'b0;
               state   <= BST_SHIFT;
            end
            BST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_cnt == LAST_BIT) begin
                        if (idx == LAST_IDX) begin
                           state <= BST_IDLE;
                        end else begin
                           idx   <= idx + 1'b1;
                           state <= BST_FETCH;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= {shreg[DW-2:0], 1'b0};
                     end
                  end
               end
            end
            default: state <= BST_IDLE;
         endcase
      end
   end

   assign rd_en    = (state == BST_FETCH);
   assign rd_addr  = idx;
   assign busy     = (state != BST_IDLE);
   assign spi_cs_n = ~busy;
   assign spi_sclk = sclk_q;
   assign spi_mosi = shreg[DW-1] & busy;

   // R8: an edge seen during a burst leaves no request behind
   p_vsync_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && vsync_rise) |=> !start_req);

   // R10: clock idles low outside a burst
   p_sclk_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R10: data does not move while the clock is high
   p_mosi_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> $stable(spi_mosi));

endmodule

// File: rtl/screen_mirror.sv
module screen_mirror
   import smir_pkg::*;
#(
   parameter int     ADDR_W       = 16,
   parameter int     DATA_W       = 8,
   parameter int     WIN_BASE     = 'h0400,
   parameter int     WIN_BYTES    = 1024,
   parameter int     SCREEN_BYTES = 1000,
   parameter int     SPI_HALF     = 4,
   parameter longint CLK_HZ       = 125_000_000,
   parameter longint BUDGET_US    = 3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rw,
   input  logic              cpu_strobe,
   input  logic              vsync,
   output logic              cpu_rdy,
   output logic              spi_sclk,
   output logic              spi_mosi,
   output logic              spi_cs_n
);

   localparam int OFF_W = $clog2(WIN_BYTES);

   generate
      if ((1 << OFF_W) != WIN_BYTES) begin : g_bad_win
         $error("WIN_BYTES must be a power of two");
      end
      if ((WIN_BASE % WIN_BYTES) != 0) begin : g_bad_base
         $error("WIN_BASE must be aligned to WIN_BYTES");
      end
      if (SCREEN_BYTES < 1 || SCREEN_BYTES > WIN_BYTES) begin : g_bad_scr
         $error("SCREEN_BYTES must lie in 1..WIN_BYTES");
      end
      if (SPI_HALF < 1 || DATA_W < 2) begin : g_bad_div
         $error("SPI_HALF must be at least 1 and DATA_W at least 2");
      end
      if (burst_cycles(SCREEN_BYTES, DATA_W, SPI_HALF) > budget_cycles(CLK_HZ, BUDGET_US)) begin : g_bad_rate
         $error("burst does not fit the vertical sync budget (R5)");
      end
   endgenerate

   logic             hit;
   logic             pending;
   logic             ram_we;
   logic [OFF_W-1:0] ram_waddr;
   logic [DATA_W-1:0] ram_wdata;
   logic             ram_re;
   logic [OFF_W-1:0] ram_raddr;
   logic [DATA_W-1:0] ram_rdata;
   logic             burst_busy;

   smir_capture #(
      .AW(ADDR_W), .DW(DATA_W), .OW(OFF_W), .BASE(WIN_BASE)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_data  (cpu_data),
      .cpu_rw    (cpu_rw),
      .cpu_strobe(cpu_strobe),
      .grant     (~burst_busy),
      .hit       (hit),
      .pending   (pending),
      .we        (ram_we),
      .waddr     (ram_waddr),
      .wdata     (ram_wdata),
      .cpu_rdy   (cpu_rdy)
   );

   smir_ram #(
      .DW(DATA_W), .DEPTH(WIN_BYTES), .AW(OFF_W)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .waddr(ram_waddr),
      .wdata(ram_wdata),
      .re   (ram_re),
      .raddr(ram_raddr),
      .rdata(ram_rdata)
   );

   smir_burst #(
      .DW(DATA_W), .AW(OFF_W), .BYTES(SCREEN_BYTES), .HALF(SPI_HALF)
   ) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .vsync   (vsync),
      .hold    (pending | hit),
      .rd_en   (ram_re),
      .rd_addr (ram_raddr),
      .rd_data (ram_rdata),
      .busy    (burst_busy),
      .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n)
   );

   // R6: the capture path never writes while the burst owns the mirror
   p_no_overlap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && burst_busy));

   // R7: a burst only opens after the processor has been released
   p_start_after_capture_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (cpu_rdy && $past(cpu_rdy)));

endmodule

// File: tb/screen_mirror_tb.sv
module screen_mirror_tb;

   localparam int NBYTES = 1000;
   localparam int BUDGET = 375000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_rw = 1'b1;
   logic        cpu_strobe = 1'b0;
   logic        vsync = 1'b0;
   logic        cpu_rdy, spi_sclk, spi_mosi, spi_cs_n;

   always #4 clk = ~clk;

   screen_mirror #(.SPI_HALF(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .vsync(vsync),
      .cpu_rdy(cpu_rdy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_mem [1024];
   logic [7:0] snap [1024];
   logic [7:0] rx [1024];
   int rx_n = 0;
   int nbits = 0;
   logic [7:0] cur = '0;
   int bursts = 0;
   int low_cyc = 0;
   int halt = 0;

   // SPI receiver: mode 0, sample on rising clock, MSB first
   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         cur = {cur[6:0], spi_mosi};
         nbits++;
         if (nbits == 8) begin
            if (rx_n < 1024) rx[rx_n] = cur;
            rx_n++;
            nbits = 0;
         end
      end
   end

   always @(negedge spi_cs_n) bursts++;
   always @(posedge clk) if (!spi_cs_n) low_cyc++;

   function automatic bit in_win(input logic [15:0] a);
      return (a >= 16'h0400) && (a <= 16'h07FF);
   endfunction

   function automatic int expected_halt(input logic [15:0] a, input logic rw);
      return (!rw && in_win(a)) ? 1 : 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic cpu_access(input logic [15:0] a, input logic [7:0] d, input logic rw);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_strobe = 1'b1;
      @(negedge clk);
      cpu_strobe = 1'b0; cpu_rw = 1'b1;
      halt = 0;
      while (!cpu_rdy && halt < 60000) begin
         @(negedge clk);
         halt++;
      end
      if (!rw && in_win(a)) exp_mem[a - 16'h0400] = d;
   endtask

   task automatic clear_rx();
      rx_n = 0; nbits = 0; low_cyc = 0;
   endtask

   task automatic wait_cs(input logic level);
      int n = 0;
      while (spi_cs_n !== level && n < 40000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic compare_burst(input string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < NBYTES; i++) begin
         if (rx[i] !== snap[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      if (first >= 0)
         check(1'b0, req, int'(rx[first]), int'(snap[first]));
      else
         check(1'b1, req, 0, 0);
      check(rx_n == NBYTES, "R5 byte count", rx_n, NBYTES);
      check(low_cyc <= BUDGET, "R5 burst length", low_cyc, BUDGET);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(cpu_rdy === 1'b1, "R9 rdy after reset", int'(cpu_rdy), 1);
      check(spi_cs_n === 1'b1, "R9 cs_n after reset", int'(spi_cs_n), 1);
      check(spi_sclk === 1'b0, "R9 sclk after reset", int'(spi_sclk), 0);
      repeat (20) @(negedge clk);
      check(bursts == 0, "R9 no burst before vsync", bursts, 0);

      // R2/R3: directed in-window write, one-cycle halt
      @(negedge clk);
      cpu_addr = 16'h0400; cpu_data = 8'hA5; cpu_rw = 1'b0; cpu_strobe = 1'b1;
      @(negedge clk);
      cpu_strobe = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h1234; cpu_data = 8'h00;
      check(cpu_rdy === 1'b0, "R2 rdy low after capture", int'(cpu_rdy), 0);
      @(negedge clk);
      check(cpu_rdy === 1'b1, "R3 rdy high after commit", int'(cpu_rdy), 1);
      exp_mem[0] = 8'hA5;

      // fill the whole window with random bytes
      for (int i = 0; i < 1024; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         cpu_access(16'h0400 + 16'(i), d, 1'b0);
         if (halt != 1) check(1'b0, "R3 halt length", halt, 1);
      end
      check(1'b1, "R3 fill halts", 1, 1);

      // R1: directed boundary accesses
      cpu_access(16'h03FF, 8'h11, 1'b0);
      check(halt == 0, "R1 write below window", halt, 0);
      cpu_access(16'h0800, 8'h22, 1'b0);
      check(halt == 0, "R1 write above window", halt, 0);
      cpu_access(16'h0400, 8'h33, 1'b1);
      check(halt == 0, "R1 read inside window", halt, 0);
      cpu_access(16'h07FF, 8'h44, 1'b0);
      check(halt == 1, "R2 write at top of window", halt, 1);

      // constrained random mix around both window edges
      for (int i = 0; i < 300; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         logic        rw;
         a  = 16'h0300 + 16'($urandom_range(0, 16'h05FF));
         d  = 8'($urandom);
         rw = 1'($urandom_range(0, 1));
         cpu_access(a, d, rw);
         if (halt != expected_halt(a, rw))
            check(1'b0, "R1 random access halt", halt, expected_halt(a, rw));
         else
            check(1'b1, "R1 random access halt", halt, expected_halt(a, rw));
      end

      // Burst 1: R4 order/content, R8 extra edge, R6 collision
      for (int i = 0; i < 1024; i++) snap[i] = exp_mem[i];
      clear_rx();
      @(negedge clk);
      vsync = 1'b1;
      wait_cs(1'b0);
      check(spi_cs_n === 1'b0, "R4 burst started", int'(spi_cs_n), 0);
      repeat (2000) @(negedge clk);
      vsync = 1'b0;
      repeat (3) @(negedge clk);
      vsync = 1'b1;                      // R8: edge during burst
      repeat (3) @(negedge clk);
      vsync = 1'b0;
      cpu_access(16'h07E7, ~snap[999], 1'b0);   // R6: offset 999 during burst
      check(spi_cs_n === 1'b1, "R6 rdy held until burst end", int'(spi_cs_n), 1);
      check(halt > 100, "R6 halt stretched by burst", halt, 101);
      check(rx[999] === snap[999], "R6 old byte sent", int'(rx[999]), int'(snap[999]));
      compare_burst("R4 burst content");
      repeat (100) @(negedge clk);
      check(bursts == 1, "R8 ignored vsync edge", bursts, 1);
      check(spi_cs_n === 1'b1, "R8 no second burst", int'(spi_cs_n), 1);

      // Burst 2: R7 capture in the cycle the burst would start
      clear_rx();
      @(negedge clk);
      vsync = 1'b1;
      cpu_access(16'h0400, ~exp_mem[0], 1'b0);
      check(halt == 1, "R7 halt not stretched", halt, 1);
      for (int i = 0; i < 1024; i++) snap[i] = exp_mem[i];
      wait_cs(1'b0);
      wait_cs(1'b1);
      vsync = 1'b0;
      check(rx[0] === snap[0], "R7 new byte in burst", int'(rx[0]), int'(snap[0]));
      check(rx[999] === snap[999], "R6 delayed byte in next burst", int'(rx[999]), int'(snap[999]));
      compare_burst("R4 burst content after priority");

      // Burst 3: R7 capture on the same edge as vsync rises
      clear_rx();
      @(negedge clk);
      cpu_addr = 16'h0401; cpu_data = ~exp_mem[1]; cpu_rw = 1'b0; cpu_strobe = 1'b1; vsync = 1'b1;
      exp_mem[1] = ~exp_mem[1];
      @(negedge clk);
      cpu_strobe = 1'b0; cpu_rw = 1'b1;
      @(negedge clk);
      check(cpu_rdy === 1'b1, "R7 pending capture first", int'(cpu_rdy), 1);
      for (int i = 0; i < 1024; i++) snap[i] = exp_mem[i];
      wait_cs(1'b0);
      wait_cs(1'b1);
      vsync = 1'b0;
      check(rx[1] === snap[1], "R7 pending byte in burst", int'(rx[1]), int'(snap[1]));
      compare_burst("R4 burst content third");
      check(bursts == 3, "R4 one burst per vsync edge", bursts, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule